// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Controller

This block watches a vector of general-purpose pads and raises interrupts when a pad shows a programmed transition. Every pad passes through a multi-flop synchronizer. A transition is found by comparing the synchronized level with its value one cycle earlier. Each pad has its own enable bit for rising transitions and its own enable bit for falling transitions. Either, both or neither may be set. An enabled transition sets a sticky status bit, and software clears that bit by writing one to it.

The pads are grouped into banks of 32. Each register type holds one 32-bit word per bank, and the bit position inside a word is the pad number modulo 32. A direction word per bank drives an output-enable per pad. Transitions are still detected on pads that are driven as outputs, because the block always looks at the level read back from the pad.

The block has three level-type interrupt lines. Pad 0 and pad 1 each own a private line. One shared line collects the status of every other pad in every bank.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every direction, rising-enable, falling-enable and status bit reads 0, every pin_oe bit is 0 and all three interrupt lines are low.
- R2: A 0-to-1 pad change on a pad whose rising enable is set sets that pad's status bit. The pad is driven before a clock edge; the status bit is still clear after two clock edges and is set after the third.
- R3: A 1-to-0 pad change on a pad whose falling enable is set sets its status bit. With both enables set, a transition in either direction sets it.
- R4: A transition whose polarity enable is clear leaves the status bit unchanged.
- R5: Writing a status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R6: When a newly detected enabled transition and a write-one-to-clear for the same bit land on the same clock edge, the bit remains set.
- R7: irq_pin0 is high exactly while status bit of pad 0 is set, and irq_pin1 is high exactly while status bit of pad 1 is set. Neither line reacts to any other pad.
- R8: irq_shared is high exactly while any status bit of pads 2 up to the last pad, in any bank, is set. Pads 0 and 1 never raise it.
- R9: The direction word of a bank reads back as written and drives pin_oe for that bank (1 = drive). Transitions on a pad with pin_oe set are still detected.
- R10: The level word of a bank returns the synchronized pad levels. A pad change is visible after two clock edges and not after one.
- R11: bus_addr[4:2] selects the register kind and bus_addr[1:0] selects the bank (pads 32*bank to 32*bank+31, bit n = pad 32*bank+n). The kinds are 0 level (read-only), 1 direction, 2 rising enable, 3 falling enable, 4 status (write one to clear). Writes take effect at the clock edge where bus_sel and bus_wr are high. Reads are combinational while bus_sel is high and bus_wr is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address: kind in [4:2], bank in [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| pad_in | input | 128 | Levels read back from the pads |
| pin_oe | output | 128 | Output enable per pad from the direction words |
| irq_pin0 | output | 1 | Interrupt for pad 0 |
| irq_pin1 | output | 1 | Interrupt for pad 1 |
| irq_shared | output | 1 | Interrupt for pads 2 to 127 |

## Verification
Transitions are applied as single rising changes, single falling changes, and a round trip on a pad that has both enables set. Together these separate a detector that follows polarity correctly from one that ignores it or swaps it. Test pads are placed in bank 0 near the private pads, in a middle bank, and at the very last pad. This shows that the status bit lands at the right bit position and that the shared line is fed by every bank while pads 0 and 1 stay on their own lines. A clear is timed to meet a fresh transition on the same edge, which tells set-wins priority apart from clear-wins. Reads taken one cycle early on the level and status words pin down the synchronizer depth.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // register kind carried in the upper address bits
   typedef enum logic [2:0] {
      KIND_LEVEL = 3'd0,
      KIND_DIR   = 3'd1,
      KIND_RISE  = 3'd2,
      KIND_FALL  = 3'd3,
      KIND_STAT  = 3'd4
   } reg_kind_e;

   localparam int unsigned KIND_W   = 3;
   localparam int unsigned MAX_WORD = 32;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync needs at least two stages");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_sync needs a nonzero width");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir,
   input  logic             wr_rise,
   input  logic             wr_fall,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] rise_q,
   output logic [WIDTH-1:0] fall_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else begin
         if (wr_dir)  dir_q  <= wdata;
         if (wr_rise) rise_q <= wdata;
         if (wr_fall) fall_q <= wdata;
      end
   end

   // R9: direction word holds what was written
   a_r9_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (dir_q == $past(wdata)));

   // R11: enable words only change on their own write strobe
   a_r11_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_rise |=> $stable(rise_q));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_s,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] stat_q
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] hit;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic up, down;
      assign up     = level_s[i] & ~prev_q[i];
      assign down   = ~level_s[i] & prev_q[i];
      assign hit[i] = (up & rise_en[i]) | (down & fall_en[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= level_s;
         // new event outranks a clear on the same edge
         stat_q <= (stat_q & ~clr_mask) | hit;
      end
   end

   // R6: a detected event always leaves its bit set
   a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((stat_q & $past(hit)) == $past(hit)));

   // R5: cleared bits without a fresh event drop
   a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_mask & ~hit)) |=> ((stat_q & $past(clr_mask & ~hit)) == '0));

   // R4: no status bit rises without a qualified event
   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 128,
   parameter int unsigned BANK_W      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NUM_BANKS  = NUM_PINS / BANK_W,
   localparam int unsigned BANK_AW    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned ADDR_W     = KIND_W + BANK_AW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BANK_W-1:0]   bus_wdata,
   output logic [BANK_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq_pin0,
   output logic                irq_pin1,
   output logic                irq_shared
);

   if (BANK_W < 2 || BANK_W > MAX_WORD) begin : g_bad_bank
      $error("bank width must lie between 2 and 32");
   end
   if (NUM_PINS % BANK_W != 0) begin : g_bad_pins
      $error("pin count must be a whole number of banks");
   end
   if (NUM_PINS < 3) begin : g_few_pins
      $error("at least three pins are needed");
   end

   reg_kind_e          kind;
   logic [BANK_AW-1:0] bank_idx;
   logic               wr_hit;

   assign kind     = reg_kind_e'(bus_addr[ADDR_W-1:BANK_AW]);
   assign bank_idx = bus_addr[BANK_AW-1:0];
   assign wr_hit   = bus_sel & bus_wr;

   logic [NUM_PINS-1:0]  level_all;
   logic [NUM_PINS-1:0]  rise_all;
   logic [NUM_PINS-1:0]  fall_all;
   logic [NUM_PINS-1:0]  stat_all;
   logic [NUM_BANKS-1:0] shared_or;

   gpio_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (level_all)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned LO = b * BANK_W;
      logic              sel_b;
      logic [BANK_W-1:0] clr_b;

      assign sel_b = wr_hit && (int'(bank_idx) == b);
      assign clr_b = (sel_b && kind == KIND_STAT) ? bus_wdata : '0;

      gpio_cfg_bank #(.WIDTH(BANK_W)) u_cfg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_dir  (sel_b && kind == KIND_DIR),
         .wr_rise (sel_b && kind == KIND_RISE),
         .wr_fall (sel_b && kind == KIND_FALL),
         .wdata   (bus_wdata),
         .dir_q   (pin_oe[LO +: BANK_W]),
         .rise_q  (rise_all[LO +: BANK_W]),
         .fall_q  (fall_all[LO +: BANK_W])
      );

      gpio_edge_bank #(.WIDTH(BANK_W)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .level_s  (level_all[LO +: BANK_W]),
         .rise_en  (rise_all[LO +: BANK_W]),
         .fall_en  (fall_all[LO +: BANK_W]),
         .clr_mask (clr_b),
         .stat_q   (stat_all[LO +: BANK_W])
      );

      // bank 0 hands its two lowest pins to the private lines
      if (b == 0) begin : g_first
         assign shared_or[b] = |stat_all[BANK_W-1:2];
      end else begin : g_rest
         assign shared_or[b] = |stat_all[LO +: BANK_W];
      end
   end

   assign irq_pin0   = stat_all[0];
   assign irq_pin1   = stat_all[1];
   assign irq_shared = |shared_or;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && int'(bank_idx) < NUM_BANKS) begin
         unique case (kind)
            KIND_LEVEL: bus_rdata = level_all[int'(bank_idx)*BANK_W +: BANK_W];
            KIND_DIR:   bus_rdata = pin_oe   [int'(bank_idx)*BANK_W +: BANK_W];
            KIND_RISE:  bus_rdata = rise_all [int'(bank_idx)*BANK_W +: BANK_W];
            KIND_FALL:  bus_rdata = fall_all [int'(bank_idx)*BANK_W +: BANK_W];
            KIND_STAT:  bus_rdata = stat_all [int'(bank_idx)*BANK_W +: BANK_W];
            default:    bus_rdata = '0;
         endcase
      end
   end

   // R7: private line only rises if pad 0 had an enable set
   a_r7_pin0_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pin0) |-> $past(rise_all[0] | fall_all[0]));

   // R7: same for pad 1
   a_r7_pin1_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pin1) |-> $past(rise_all[1] | fall_all[1]));

   // R8: shared line needs an enabled pad above pad 1
   a_r8_shared_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_shared) |-> $past(|(rise_all[NUM_PINS-1:2] | fall_all[NUM_PINS-1:2])));

endmodule

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;

   localparam int unsigned NP = 128;
   localparam int unsigned BW = 32;

   localparam logic [2:0] K_LVL  = 3'd0;
   localparam logic [2:0] K_DIR  = 3'd1;
   localparam logic [2:0] K_RISE = 3'd2;
   localparam logic [2:0] K_FALL = 3'd3;
   localparam logic [2:0] K_STAT = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_sel;
   logic          bus_wr;
   logic [4:0]    bus_addr;
   logic [BW-1:0] bus_wdata;
   logic [BW-1:0] bus_rdata;
   logic [NP-1:0] pad;
   logic [NP-1:0] oe;
   logic          irq0, irq1, irqs;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   gpio_edge_irq i_gpio_edge_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pad_in     (pad),
      .pin_oe     (oe),
      .irq_pin0   (irq0),
      .irq_pin1   (irq1),
      .irq_shared (irqs)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [2:0] k, input logic [1:0] b, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {k, b}; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] k, input logic [1:0] b, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {k, b};
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int b = 0; b < 4; b++) begin
         rd(K_DIR, 2'(b), v);  check("R1 dir reset", v, 0);
         rd(K_RISE, 2'(b), v); check("R1 rise reset", v, 0);
         rd(K_FALL, 2'(b), v); check("R1 fall reset", v, 0);
         rd(K_STAT, 2'(b), v); check("R1 stat reset", v, 0);
      end
      check("R1 oe reset", 32'(|oe), 0);
      check("R1 irq reset", {29'd0, irq0, irq1, irqs}, 0);
   endtask

   task automatic t_rise();
      logic [31:0] v;
      wr(K_RISE, 0, 32'h20);
      pad[5] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rd(K_STAT, 0, v); check("R2 not yet after two edges", v, 0);
      @(posedge clk);
      @(negedge clk);
      rd(K_STAT, 0, v); check("R2 rise latched", v, 32'h20);
      check("R8 shared from pad 5", 32'(irqs), 1);
      check("R7 private lines quiet", {30'd0, irq0, irq1}, 0);
      wr(K_STAT, 0, 32'h0);
      rd(K_STAT, 0, v); check("R5 zero write keeps bit", v, 32'h20);
      wr(K_STAT, 0, 32'h20);
      rd(K_STAT, 0, v); check("R5 one write clears", v, 0);
      check("R8 shared drops", 32'(irqs), 0);
      pad[5] = 1'b0;
      settle();
      rd(K_STAT, 0, v); check("R4 fall ignored with rise only", v, 0);
      wr(K_RISE, 0, 0);
   endtask

   task automatic t_fall();
      logic [31:0] v;
      wr(K_FALL, 2, 32'h8);
      pad[67] = 1'b1;
      settle();
      rd(K_STAT, 2, v); check("R4 rise ignored with fall only", v, 0);
      pad[67] = 1'b0;
      settle();
      rd(K_STAT, 2, v); check("R3 fall latched bank 2 bit 3 (R11)", v, 32'h8);
      rd(K_STAT, 0, v); check("R11 other bank untouched", v, 0);
      wr(K_STAT, 2, 32'h8);
      wr(K_FALL, 2, 0);
   endtask

   task automatic t_both();
      logic [31:0] v;
      wr(K_RISE, 1, 32'h100);
      wr(K_FALL, 1, 32'h100);
      pad[40] = 1'b1;
      settle();
      rd(K_STAT, 1, v); check("R3 both: rise", v, 32'h100);
      wr(K_STAT, 1, 32'h100);
      pad[40] = 1'b0;
      settle();
      rd(K_STAT, 1, v); check("R3 both: fall", v, 32'h100);
      wr(K_STAT, 1, 32'h100);
      wr(K_RISE, 1, 0);
      wr(K_FALL, 1, 0);
   endtask

   task automatic t_pin01();
      wr(K_RISE, 0, 32'h3);
      pad[0] = 1'b1;
      settle();
      check("R7 pad 0 line", {29'd0, irq0, irq1, irqs}, 32'h4);
      wr(K_STAT, 0, 32'h1);
      check("R7 pad 0 cleared", 32'(irq0), 0);
      pad[1] = 1'b1;
      settle();
      check("R7 pad 1 line, R8 shared quiet", {29'd0, irq0, irq1, irqs}, 32'h2);
      wr(K_STAT, 0, 32'h2);
      wr(K_RISE, 0, 0);
      pad[1:0] = 2'b00;
      settle();
      check("R7 lines low", {29'd0, irq0, irq1, irqs}, 0);
   endtask

   task automatic t_top();
      logic [31:0] v;
      wr(K_FALL, 3, 32'h8000_0000);
      pad[127] = 1'b1;
      settle();
      pad[127] = 1'b0;
      settle();
      check("R8 shared from last pad", 32'(irqs), 1);
      rd(K_STAT, 3, v); check("R11 last pad at bit 31", v, 32'h8000_0000);
      wr(K_STAT, 3, 32'h8000_0000);
      check("R8 shared cleared", 32'(irqs), 0);
      wr(K_FALL, 3, 0);
   endtask

   task automatic t_dir();
      logic [31:0] v;
      wr(K_DIR, 1, 32'hA5A5_0001);
      rd(K_DIR, 1, v); check("R9 dir readback", v, 32'hA5A5_0001);
      check("R9 oe bank 1", oe[63:32], 32'hA5A5_0001);
      check("R9 oe bank 0", oe[31:0], 0);
      wr(K_RISE, 1, 32'h1);
      pad[32] = 1'b1;
      settle();
      rd(K_STAT, 1, v); check("R9 output pad still detected", v, 32'h1);
      wr(K_STAT, 1, 32'h1);
      wr(K_RISE, 1, 0);
      wr(K_DIR, 1, 0);
      check("R9 oe cleared", oe[63:32], 0);
      pad[32] = 1'b0;
      settle();
   endtask

   task automatic t_level();
      logic [31:0] v;
      pad[127:96] = 32'h1234_5678;
      @(posedge clk);
      @(negedge clk);
      rd(K_LVL, 3, v); check("R10 level after one edge", v, 0);
      @(posedge clk);
      @(negedge clk);
      rd(K_LVL, 3, v); check("R10 level after two edges", v, 32'h1234_5678);
      pad[127:96] = '0;
      settle();
   endtask

   task automatic t_race();
      logic [31:0] v;
      wr(K_RISE, 0, 32'h400);
      wr(K_FALL, 0, 32'h400);
      pad[10] = 1'b1;
      settle();
      rd(K_STAT, 0, v); check("R6 setup", v, 32'h400);
      pad[10] = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      wr(K_STAT, 0, 32'h400);
      rd(K_STAT, 0, v); check("R6 event beats clear", v, 32'h400);
      wr(K_STAT, 0, 32'h400);
      rd(K_STAT, 0, v); check("R5 plain clear", v, 0);
      wr(K_RISE, 0, 0);
      wr(K_FALL, 0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      bus_addr = '0; bus_wdata = '0; pad = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rise();
      t_fall();
      t_both();
      t_pin01();
      t_top();
      t_dir();
      t_level();
      t_race();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule